// File: doc/BRIEF.md
# Selectable Ratio Clock Divider

This block divides an incoming clock by one of nine fixed ratios: 1, 2, 3, 4, 5, 6, 8, 10 and 12. The ratio is chosen by two select inputs. Each carries one of three levels (LOW, MID, HIGH) as a 2-bit code, so together they form nine codes. The divided clock leaves the block on a group of identical outputs, two by default, so that a matched pair can fan out to separate loads.

Every ratio keeps the high and low phases equal, including the odd ones. For an odd ratio, a register clocked on the falling edge stretches the high phase by half an input period. At ratio 1 the outputs follow the input clock.

A change of select does not cut the running period short. The new code is captured in a register and takes over only where the current output period ends. A synchronous active-low reset holds the outputs low. It also loads the counter with a start state that depends on the ratio the live selects pick, so the first period after release is a full one.

Top module: `clkdiv_top`

## Requirements
- R1: Level codes are 2'b00 = LOW, 2'b01 = MID and 2'b10 = HIGH. The pair (sel_major, sel_minor) maps to a ratio N as follows: (LOW,LOW)=1, (LOW,MID)=2, (LOW,HIGH)=3, (MID,LOW)=4, (MID,MID)=5, (MID,HIGH)=6, (HIGH,LOW)=8, (HIGH,MID)=10, (HIGH,HIGH)=12. Each output period lasts N input periods.
- R2: A level code of 2'b11 on either select is treated as MID.
- R3: At every ratio each output is high for exactly N/2 input periods of each period. For odd N this includes the extra half period added on the falling edge, and the high phase starts where the period starts.
- R4: All bits of clk_out carry the same waveform at all times.
- R5: While rst_n is low at a rising clock edge, every output is held low. On release, the first rising edge of the input clock starts a full output period: the output is high for N half input periods and then low for N half input periods, with N taken from the selects applied during reset.
- R6: At ratio 1, once out of reset, the outputs are high while the input clock is high and low while it is low.
- R7: A select change is registered and applied only at the next output period boundary. Every high and low phase observed across the change lasts the full length of either the old ratio or the new ratio, and once a phase of the new length appears, no phase of the old length follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_major | input | 2 | First three-level ratio select (LOW/MID/HIGH code) |
| sel_minor | input | 2 | Second three-level ratio select (LOW/MID/HIGH code) |
| clk_out | output | N_OUT | Identical divided clock outputs |

## Verification
Some properties are checked on every rising edge:
- the active ratio is one of the nine legal values;
- the counter stays below the ratio and stays at zero at ratio 1;
- the ratio changes only at a counter wrap;
- the counter holds its ratio-dependent start state when reset releases;
- the output bits agree with each other.

Duty cycle and period are only visible by sampling the outputs at every half input period, so the bench's scenarios have to show them. The same holds for the half-period stretch on odd ratios, the ratio-1 pass-through, the alias of code 2'b11, and the absence of runt phases when the select moves in the middle of a period.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants, level encoding and ratio decode for the
// selectable ratio clock divider. Assumes each select is a 2-bit level code.
package clkdiv_pkg;
    localparam int unsigned LVL_W     = 2;
    localparam int unsigned LEVELS    = 3;
    localparam int unsigned RATIO_MAX = 12;
    localparam int unsigned RATIO_W   = $clog2(RATIO_MAX + 1);

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW   = 2'b00,
        LVL_MID   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_ALIAS = 2'b11
    } lvl_code_e;

    // Rank of a level code; the unused code aliases to MID.
    function automatic int unsigned lvl_rank(input logic [LVL_W-1:0] code);
        case (lvl_code_e'(code))
            LVL_LOW:  return 0;
            LVL_HIGH: return 2;
            default:  return 1;
        endcase
    endfunction

    // Ratio for a pair of ranks: first six codes count up, last three step by two from 8.
    function automatic int unsigned ratio_for(input int unsigned major, input int unsigned minor);
        int unsigned idx;
        idx = major * LEVELS + minor;
        if (idx < 6) return idx + 1;
        return 8 + 2 * (idx - 6);
    endfunction
endpackage

// File: rtl/clkdiv_decode.sv
// Module: clkdiv_decode
// Turns two three-level select codes into a binary division ratio.
// Assumes: purely combinational; the caller registers the selects if needed.
module clkdiv_decode
    import clkdiv_pkg::*;
(
    input  logic [LVL_W-1:0]   sel_major,
    input  logic [LVL_W-1:0]   sel_minor,
    output logic [RATIO_W-1:0] ratio
);
    // Decode the two level ranks into a ratio value.
    always_comb begin
        ratio = RATIO_W'(ratio_for(lvl_rank(sel_major), lvl_rank(sel_minor)));
    end
endmodule

// File: rtl/clkdiv_seq.sv
// Module: clkdiv_seq
// Period counter. It holds the active ratio and produces the registered
// high-phase flag. The requested ratio is adopted only when the counter wraps.
// Assumes: ratio inputs are legal (1..RATIO_MAX); synchronous active-low reset.
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_live,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] cnt_q,
    output logic               hi_q,
    output logic               run_q
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic               wrap;
    logic [RATIO_W-1:0] ratio_d;
    logic [RATIO_W-1:0] cnt_d;
    logic               hi_d;

    // Next-state: wrap at the last count, pick up the new ratio there.
    always_comb begin
        wrap    = (cnt_q == ratio_q - ONE);
        ratio_d = wrap ? ratio_req : ratio_q;
        cnt_d   = wrap ? '0 : cnt_q + ONE;
        hi_d    = (cnt_d < (ratio_d >> 1));
    end

    // State update; reset parks the counter at the last count of the live ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ratio_live;
            cnt_q   <= ratio_live - ONE;
            hi_q    <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            ratio_q <= ratio_d;
            cnt_q   <= cnt_d;
            hi_q    <= hi_d;
            run_q   <= 1'b1;
        end
    end
endmodule

// File: rtl/clkdiv_shaper.sv
// Module: clkdiv_shaper
// Forms the final waveform. Even ratios use the rising-edge phase flag as is.
// Odd ratios OR in a copy delayed by half a period to stretch the high phase.
// Ratio 1 passes the input clock through while running.
// Assumes: ratio_q, hi_q and run_q change only on the rising edge of clk.
module clkdiv_shaper
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = 2
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_q,
    input  logic               hi_q,
    input  logic               run_q,
    output logic [N_OUT-1:0]   clk_out
);
    logic lag_q;
    logic shaped;

    // Falling-edge copy of the high flag for half-period stretch.
    always_ff @(negedge clk) begin
        if (!rst_n) lag_q <= 1'b0;
        else        lag_q <= hi_q;
    end

    // Select the waveform that fits the active ratio.
    always_comb begin
        if (ratio_q == RATIO_W'(1))  shaped = clk & run_q;
        else if (ratio_q[0])         shaped = hi_q | lag_q;
        else                         shaped = hi_q;
    end

    // Fan the one waveform out to every output copy.
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign clk_out[g] = shaped;
    end
endmodule

// File: rtl/clkdiv_top.sv
// Module: clkdiv_top
// Selectable ratio clock divider driving N_OUT identical outputs at a 50%
// duty cycle.
// Assumes: the selects are quasi-static level codes synchronous to clk;
// rst_n is synchronous and active low.
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = 2
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] sel_major,
    input  logic [LVL_W-1:0] sel_minor,
    output logic [N_OUT-1:0] clk_out
);
    logic [LVL_W-1:0]   selq_major;
    logic [LVL_W-1:0]   selq_minor;
    logic [RATIO_W-1:0] ratio_live;
    logic [RATIO_W-1:0] ratio_req;
    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;
    logic               hi_q;
    logic               run_q;

    // Capture the selects every cycle; the counter consumes them at a wrap.
    always_ff @(posedge clk) begin
        selq_major <= sel_major;
        selq_minor <= sel_minor;
    end

    clkdiv_decode u_dec_live (
        .sel_major (sel_major),
        .sel_minor (sel_minor),
        .ratio     (ratio_live)
    );

    clkdiv_decode u_dec_held (
        .sel_major (selq_major),
        .sel_minor (selq_minor),
        .ratio     (ratio_req)
    );

    clkdiv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_live (ratio_live),
        .ratio_req  (ratio_req),
        .ratio_q    (ratio_q),
        .cnt_q      (cnt_q),
        .hi_q       (hi_q),
        .run_q      (run_q)
    );

    clkdiv_shaper #(.N_OUT(N_OUT)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_q (ratio_q),
        .hi_q    (hi_q),
        .run_q   (run_q),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkdiv_checker.sv
// Module: clkdiv_checker
// Concurrent checks on the divider state and outputs; bound to clkdiv_top.
// Assumes: sampled on the rising edge of clk, disabled while rst_n is low.
module clkdiv_checker
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = 2
)
(
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_q,
    input logic [RATIO_W-1:0] cnt_q,
    input logic               hi_q,
    input logic [N_OUT-1:0]   clk_out
);
    a_r1_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q inside {1, 2, 3, 4, 5, 6, 8, 10, 12});

    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q);

    a_r4_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out == {N_OUT{clk_out[0]}});

    a_r5_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((cnt_q == ratio_q - 1'b1) && !hi_q));

    a_r6_unit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_q == 1) |-> (cnt_q == 0));

    a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != ratio_q - 1'b1) |=> $stable(ratio_q));
endmodule

bind clkdiv_top clkdiv_checker #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ratio_q (ratio_q),
    .cnt_q   (cnt_q),
    .hi_q    (hi_q),
    .clk_out (clk_out)
);

// File: tb/tb_clkdiv_top.sv
`timescale 1ns/1ps
// Directed bench for clkdiv_top. Outputs are sampled 2 ns after every clock
// edge, which gives one sample per half input period.
module tb_clkdiv_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_major = 2'b00;
    logic [1:0] sel_minor = 2'b00;
    logic [1:0] clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int run_len[64];
    int mism;
    int exp_tab[9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};

    always #4 clk = ~clk;

    clkdiv_top #(.N_OUT(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_major (sel_major),
        .sel_minor (sel_minor),
        .clk_out   (clk_out)
    );

    // Record one check result.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the next half-period sample point and read the outputs.
    task automatic sample(output logic v);
        @(clk);
        #2;
        if (clk_out[0] !== clk_out[1]) mism++;
        v = clk_out[0];
    endtask

    // Sync to a rising output, then record the lengths of nruns phases.
    task automatic collect(input int nruns, output bit ok);
        logic prev, cur;
        int   idx, len;
        ok = 1'b0;
        sample(cur);
        for (int g = 0; g < 400; g++) begin
            prev = cur;
            sample(cur);
            if (prev === 1'b0 && cur === 1'b1) begin
                ok = 1'b1;
                break;
            end
        end
        if (!ok) return;
        idx = 0;
        len = 1;
        while (idx < nruns) begin
            prev = cur;
            sample(cur);
            if (cur === prev) len++;
            else begin
                run_len[idx] = len;
                idx++;
                len = 1;
            end
        end
    endtask

    task automatic set_sel(input logic [1:0] maj, input logic [1:0] mnr);
        @(negedge clk);
        #1;
        sel_major = maj;
        sel_minor = mnr;
    endtask

    // R5/R6: outputs low in reset, then one full period right after release.
    task automatic t_reset(input logic [1:0] maj, input logic [1:0] mnr, input int n, input string req);
        logic v;
        int   highs, errs;
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        sel_major = maj;
        sel_minor = mnr;
        repeat (3) @(posedge clk);
        highs = 0;
        for (int i = 0; i < 6; i++) begin
            sample(v);
            if (v !== 1'b0) highs++;
        end
        check(highs == 0, "R5 outputs low in reset", highs, 0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        v = clk_out[0];
        errs = 0;
        for (int i = 0; i < 2 * n; i++) begin
            if (i > 0) sample(v);
            if (v !== (i < n)) errs++;
        end
        check(errs == 0, {req, " first period after release"}, errs, 0);
    endtask

    // R1/R3/R4: period, duty and pair match for one select code.
    task automatic t_ratio(input logic [1:0] maj, input logic [1:0] mnr, input int n, input string req);
        bit ok;
        int bad_per, bad_duty;
        set_sel(maj, mnr);
        repeat (30) @(posedge clk);
        mism = 0;
        collect(8, ok);
        bad_per = 0;
        bad_duty = 0;
        for (int k = 0; k < 4; k++) begin
            if (run_len[2*k] + run_len[2*k+1] != 2 * n) bad_per++;
            if (run_len[2*k] != run_len[2*k+1]) bad_duty++;
        end
        check(ok && bad_per == 0, {req, " period"}, run_len[0] + run_len[1], 2 * n);
        check(ok && bad_duty == 0, "R3 equal high and low phases", run_len[0], run_len[1]);
        check(mism == 0, "R4 outputs identical", mism, 0);
    endtask

    // R7: a select change mid-period gives only full old or new phases.
    task automatic t_change(input logic [1:0] m0, input logic [1:0] s0, input int n0,
                            input logic [1:0] m1, input logic [1:0] s1, input int n1);
        bit ok;
        int bad;
        bit seen_new;
        set_sel(m0, s0);
        repeat (30) @(posedge clk);
        fork
            collect(24, ok);
            begin
                repeat (3 * n0 + 1) @(posedge clk);
                set_sel(m1, s1);
            end
        join
        bad = 0;
        seen_new = 1'b0;
        for (int k = 0; k < 24; k++) begin
            if (run_len[k] != n0 && run_len[k] != n1) bad++;
            if (run_len[k] == n1) seen_new = 1'b1;
            else if (seen_new) bad++;
        end
        check(ok && bad == 0, "R7 no runt phase across change", bad, 0);
        check(run_len[23] == n1, "R7 new ratio in effect", run_len[23], n1);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset(2'b01, 2'b00, 4, "R5");
        t_reset(2'b00, 2'b10, 3, "R5");
        t_reset(2'b00, 2'b00, 1, "R6");
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                t_ratio(2'(a), 2'(b), exp_tab[a*3+b], (a == 0 && b == 0) ? "R6" : "R1");
            end
        end
        t_ratio(2'b11, 2'b00, 4, "R2");
        t_ratio(2'b00, 2'b11, 2, "R2");
        t_ratio(2'b11, 2'b11, 5, "R2");
        t_change(2'b10, 2'b10, 12, 2'b00, 2'b00, 1);
        t_change(2'b00, 2'b00, 1, 2'b10, 2'b10, 12);
        t_change(2'b00, 2'b10, 3, 2'b01, 2'b00, 4);
        t_change(2'b01, 2'b01, 5, 2'b00, 2'b01, 2);
        t_change(2'b01, 2'b10, 6, 2'b01, 2'b01, 5);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule